// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block sits behind a clock synthesiser and decides, cycle by cycle, which of its generated clocks reach the board. It takes two source waveforms: one for a bus clock group and one for a differential processor clock pair. It also takes three active-low control pins (bus stop, processor stop, power-down), a mode bit that arms those pins, and one enable bit per output. All of these are sampled by a fast system clock `clk`. The source waveforms are oversampled levels in the `clk` domain. Every output is a registered, gated copy of its source, one `clk` cycle behind it.

Each gate changes state only at a rising edge of its own source, so an output can only start or stop on a phase boundary. A stop lets the current high phase finish and then holds the output low. A restart begins with a complete high phase. Outputs with indices below `NUM_FREE` are free-running: the bus stop pin has no effect on them. The processor pair uses a synchroniser of `SYNC_STAGES` source edges before it parks at true-low and complement-high. Power-down acts at once on every output, free-running ones included. When the mode bit is low, all three control pins are ignored.

Top module: `clock_stop_ctrl`

## Requirements
- R1: While the bus stop is active, an output with index at least `NUM_FREE` finishes the high phase already in progress. It then stays low from its next falling edge until the stop is released.
- R2: Bus outputs with index below `NUM_FREE` keep following their source whether or not the bus stop is active.
- R3: A request is taken from the `clk` cycle in which the source rise is seen (source high, previous sample low). If the request is present in that cycle, the whole high phase starting there is suppressed. If it arrives one cycle later, it takes effect at the next rise. Each output lags its source by one `clk` cycle.
- R4: Suppose the processor stop is present in the cycle of a processor source rise. Then `cpu_t` gives exactly two more high pulses (SYNC_STAGES = 2) and stays low afterwards.
- R5: A stopped but enabled pair sits at `cpu_t` = 0 and `cpu_c` = 1. A running pair has `cpu_c` equal to the inverse of `cpu_t`. The two outputs are never high together.
- R6: With `stop_mode` = 0, `pci_stop_n`, `cpu_stop_n` and `pwrdn_n` have no effect, and every enabled output keeps toggling.
- R7: An output whose enable bit is 0 goes low from the next rise of its source, whatever the stop pins say. A disabled processor pair drives both `cpu_t` and `cpu_c` to 0.
- R8: With `stop_mode` = 1 and `pwrdn_n` = 0, every output, free-running ones included, is 0 one `clk` cycle later. After release, outputs restart only at a source rise.
- R9: Every high phase on a gated output lasts exactly as long as the source high phase. The only exception is a phase cut short by power-down.
- R10: While `rst_n` is 0 at a `clk` edge, all outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pci_src | input | 1 | Bus clock source waveform |
| cpu_src | input | 1 | Processor clock source waveform |
| stop_mode | input | 1 | 1 arms the three control pins |
| pci_stop_n | input | 1 | Active-low bus group stop request |
| cpu_stop_n | input | 1 | Active-low processor pair stop request |
| pwrdn_n | input | 1 | Active-low power-down of all outputs |
| pci_en | input | NUM_PCI | Per-output enable of the bus group |
| cpu_en | input | 1 | Enable of the processor pair |
| pci_clk | output | NUM_PCI | Gated bus clocks, low indices free-running |
| cpu_t | output | 1 | Processor pair true output |
| cpu_c | output | 1 | Processor pair complement output |

## Verification
The assertions check the following on every cycle: a gated output rises only after a source rise, it is never high without a high source, power-down forces it low, and the two processor outputs are never high together. They also check that the pair drops once the synchroniser holds a request, and that free-running and mode-disarmed outputs follow a source rise. The bench scenarios cover what needs a whole sequence of edges. These are: the setup boundary of a stop request relative to a rise, the count of exactly two trailing processor pulses, the parked level once stopped, and that every high phase after a release has full width.

// File: rtl/clock_stop_pkg.sv
// Package: shared types and helpers for the clock stop controller.
// Assumes all control pins are sampled in the clk domain.
package clock_stop_pkg;

    // Levels of the differential processor pair.
    typedef struct packed {
        logic t;
        logic c;
    } pair_lvl_t;

    localparam pair_lvl_t PAIR_OFF = '{t: 1'b0, c: 1'b0};

    // An active-low pin counts only when the mode bit arms it.
    function automatic logic pin_active(input logic mode, input logic pin_n);
        return mode & ~pin_n;
    endfunction

endpackage

// File: rtl/stop_gate_cell.sv
// Module: stop_gate_cell
// Gates one oversampled clock waveform. The run state changes only in a
// cycle where the source rise is seen, so the output starts and stops on
// phase boundaries. kill_i clears the run state and forces the output low
// at once. Assumes rise_i is high for exactly one cycle per source period.
module stop_gate_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic rise_i,
    input  logic allow_i,
    input  logic kill_i,
    output logic clk_o
);

    logic run_q;
    logic run_nxt;

    // Next run state: cleared by kill, reloaded only at a source rise.
    always_comb begin
        if (kill_i)      run_nxt = 1'b0;
        else if (rise_i) run_nxt = allow_i;
        else             run_nxt = run_q;
    end

    // Register the run state and the gated output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            clk_o <= 1'b0;
        end else begin
            run_q <= run_nxt;
            clk_o <= src_i & run_nxt;
        end
    end

    a_r9_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_o) |-> $past(rise_i));
    a_r1_high_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
        clk_o |-> $past(src_i));
    a_r8_kill_low: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> !clk_o);

endmodule

// File: rtl/cpu_pair_stop.sv
// Module: cpu_pair_stop
// Gates the differential processor pair. A stop request passes a shift
// chain advanced on source rises before the pair parks at true-low,
// complement-high. Disable and kill drive both outputs low.
// Assumes SYNC_STAGES >= 2 and rise_i one cycle wide.
module cpu_pair_stop
    import clock_stop_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic rise_i,
    input  logic req_i,
    input  logic en_i,
    input  logic kill_i,
    output logic t_o,
    output logic c_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          run_q;
    logic          run_nxt;
    logic          en_q;
    logic          en_nxt;
    pair_lvl_t     lvl_nxt;

    // Shift the request along the chain, one stage per source rise.
    always_ff @(posedge clk) begin
        if (!rst_n)      sync_q <= '0;
        else if (rise_i) sync_q <= {sync_q[LAST-1:0], req_i};
    end

    // Next run and enable state, updated only at a rise or on kill.
    always_comb begin
        if (kill_i) begin
            run_nxt = 1'b0;
            en_nxt  = 1'b0;
        end else if (rise_i) begin
            run_nxt = en_i & ~sync_q[LAST];
            en_nxt  = en_i;
        end else begin
            run_nxt = run_q;
            en_nxt  = en_q;
        end
        lvl_nxt.t = src_i & run_nxt;
        lvl_nxt.c = en_nxt & ~(src_i & run_nxt);
    end

    // Register the pair state and output levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            en_q  <= 1'b0;
            t_o   <= PAIR_OFF.t;
            c_o   <= PAIR_OFF.c;
        end else begin
            run_q <= run_nxt;
            en_q  <= en_nxt;
            t_o   <= lvl_nxt.t;
            c_o   <= lvl_nxt.c;
        end
    end

    a_r4_stop_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && sync_q[LAST]) |=> !t_o);
    a_r5_never_both_high: assert property (@(posedge clk) disable iff (!rst_n)
        !(t_o && c_o));
    a_r8_pair_kill: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> (!t_o && !c_o));
    a_r9_pair_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_o) |-> $past(rise_i));

endmodule

// File: rtl/clock_stop_ctrl.sv
// Module: clock_stop_ctrl (top)
// Detects source rises, decodes the armed control pins, and instantiates
// one gate cell per bus output plus the processor pair. Outputs with
// index below NUM_FREE are exempt from the bus stop.
// Assumes NUM_FREE <= NUM_PCI and sources slower than clk / 2.
module clock_stop_ctrl
    import clock_stop_pkg::*;
#(
    parameter int NUM_PCI     = 8,
    parameter int NUM_FREE    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pci_src,
    input  logic               cpu_src,
    input  logic               stop_mode,
    input  logic               pci_stop_n,
    input  logic               cpu_stop_n,
    input  logic               pwrdn_n,
    input  logic [NUM_PCI-1:0] pci_en,
    input  logic               cpu_en,
    output logic [NUM_PCI-1:0] pci_clk,
    output logic               cpu_t,
    output logic               cpu_c
);

    logic pci_src_q;
    logic cpu_src_q;
    logic pci_rise;
    logic cpu_rise;
    logic pci_stop_req;
    logic cpu_stop_req;
    logic kill;

    // Keep last source samples for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pci_src_q <= 1'b0;
            cpu_src_q <= 1'b0;
        end else begin
            pci_src_q <= pci_src;
            cpu_src_q <= cpu_src;
        end
    end

    // Decode rises and armed control pins.
    always_comb begin
        pci_rise     = pci_src & ~pci_src_q;
        cpu_rise     = cpu_src & ~cpu_src_q;
        pci_stop_req = pin_active(stop_mode, pci_stop_n);
        cpu_stop_req = pin_active(stop_mode, cpu_stop_n);
        kill         = pin_active(stop_mode, pwrdn_n);
    end

    for (genvar i = 0; i < NUM_PCI; i++) begin : g_pci
        logic allow;
        if (i < NUM_FREE) begin : g_free
            assign allow = pci_en[i];

            a_r2_free_follows: assert property (@(posedge clk) disable iff (!rst_n)
                (pci_rise && pci_en[i] && !kill) |=> pci_clk[i]);
        end else begin : g_stoppable
            assign allow = pci_en[i] & ~pci_stop_req;
        end

        stop_gate_cell u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (pci_src),
            .rise_i  (pci_rise),
            .allow_i (allow),
            .kill_i  (kill),
            .clk_o   (pci_clk[i])
        );
    end

    cpu_pair_stop #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cpu (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (cpu_src),
        .rise_i (cpu_rise),
        .req_i  (cpu_stop_req),
        .en_i   (cpu_en),
        .kill_i (kill),
        .t_o    (cpu_t),
        .c_o    (cpu_c)
    );

    if (NUM_FREE < NUM_PCI) begin : g_mode_chk
        a_r6_mode_off_runs: assert property (@(posedge clk) disable iff (!rst_n)
            (!stop_mode && pci_rise && pci_en[NUM_PCI-1]) |=> pci_clk[NUM_PCI-1]);
    end

endmodule

// File: tb/clock_stop_ctrl_tb.sv
module clock_stop_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int NF = 2;
    localparam int PH = 3;   // bus source half period in clk cycles
    localparam int CH = 2;   // processor source half period in clk cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pci_src = 1'b0, cpu_src = 1'b0;
    logic stop_mode = 1'b1, pci_stop_n = 1'b1, cpu_stop_n = 1'b1, pwrdn_n = 1'b1;
    logic [NP-1:0] pci_en = '1;
    logic cpu_en = 1'b1;
    logic [NP-1:0] pci_clk;
    logic cpu_t, cpu_c;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    int pcnt = 0, ccnt = 0;
    bit pci_rose = 1'b0, cpu_rose = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clock_stop_ctrl #(.NUM_PCI(NP), .NUM_FREE(NF), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pci_src(pci_src), .cpu_src(cpu_src),
        .stop_mode(stop_mode), .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n),
        .pwrdn_n(pwrdn_n), .pci_en(pci_en), .cpu_en(cpu_en),
        .pci_clk(pci_clk), .cpu_t(cpu_t), .cpu_c(cpu_c));

    // Reference model of the requirements, advanced at each clk edge.
    logic m_psq, m_csq, m_s1, m_s2, m_crun, m_cen, m_t, m_c;
    logic [NP-1:0] m_run, m_pci;
    always @(posedge clk) begin
        logic kl, pst, cst, pr, cr, rn_c, en_c;
        logic [NP-1:0] rn;
        if (!rst_n) begin
            m_psq <= 0; m_csq <= 0; m_s1 <= 0; m_s2 <= 0; m_crun <= 0;
            m_cen <= 0; m_t <= 0; m_c <= 0; m_run <= '0; m_pci <= '0;
        end else begin
            kl  = stop_mode & ~pwrdn_n;
            pst = stop_mode & ~pci_stop_n;
            cst = stop_mode & ~cpu_stop_n;
            pr  = pci_src & ~m_psq;
            cr  = cpu_src & ~m_csq;
            for (int i = 0; i < NP; i++) begin
                if (kl) rn[i] = 1'b0;
                else if (pr) rn[i] = pci_en[i] & ((i < NF) | ~pst);
                else rn[i] = m_run[i];
            end
            rn_c = kl ? 1'b0 : (cr ? (cpu_en & ~m_s2) : m_crun);
            en_c = kl ? 1'b0 : (cr ? cpu_en : m_cen);
            if (cr) begin m_s1 <= cst; m_s2 <= m_s1; end
            m_psq <= pci_src; m_csq <= cpu_src;
            m_run <= rn; m_crun <= rn_c; m_cen <= en_c;
            m_pci <= rn & {NP{pci_src & ~kl}};
            m_t <= cpu_src & rn_c;
            m_c <= en_c & ~(cpu_src & rn_c);
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // High-phase width monitors for R9.
    int hl_p = 0, hl_c = 0;
    bit ok_p = 1'b0, ok_c = 1'b0;
    task automatic width_mon();
        if (!rst_n || (stop_mode && !pwrdn_n)) begin ok_p = 0; ok_c = 0; end
        if (pci_clk[NP-1]) hl_p++;
        else begin
            if (hl_p > 0 && ok_p) check(hl_p == PH, "R9 bus high width", hl_p, PH);
            if (hl_p > 0 || rst_n) ok_p = rst_n && !(stop_mode && !pwrdn_n);
            hl_p = 0;
        end
        if (cpu_t) hl_c++;
        else begin
            if (hl_c > 0 && ok_c) check(hl_c == CH, "R9 cpu high width", hl_c, CH);
            if (hl_c > 0 || rst_n) ok_c = rst_n && !(stop_mode && !pwrdn_n);
            hl_c = 0;
        end
    endtask

    // One clk cycle: compare at the falling edge, then advance sources.
    task automatic tick();
        @(negedge clk);
        check(pci_clk[NF-1:0] == m_pci[NF-1:0], "R2 free bus outputs", pci_clk[NF-1:0], m_pci[NF-1:0]);
        check(pci_clk[NP-1:NF] == m_pci[NP-1:NF], "R1 stoppable bus outputs", pci_clk[NP-1:NF], m_pci[NP-1:NF]);
        check(cpu_t == m_t, "R4 cpu true", cpu_t, m_t);
        check(cpu_c == m_c, "R5 cpu complement", cpu_c, m_c);
        width_mon();
        pci_rose = 1'b0; cpu_rose = 1'b0;
        pcnt++;
        if (pcnt == PH) begin pcnt = 0; pci_src = ~pci_src; pci_rose = pci_src; end
        ccnt++;
        if (ccnt == CH) begin ccnt = 0; cpu_src = ~cpu_src; cpu_rose = cpu_src; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int rises, hi_seen, fr_seen;
        logic prev;
        void'($urandom(32'd20250517));
        // R10: reset holds outputs low.
        repeat (4) tick();
        check(pci_clk == '0 && !cpu_t && !cpu_c, "R10 reset outputs", {pci_clk, cpu_t, cpu_c}, 0);
        rst_n = 1'b1;
        repeat (20) tick();

        // R3: stop present in the rise cycle suppresses that phase.
        do tick(); while (!pci_rose);
        pci_stop_n = 1'b0;
        hi_seen = 0; fr_seen = 0;
        repeat (4 * PH) begin tick(); hi_seen += pci_clk[NP-1]; fr_seen += pci_clk[0]; end
        check(hi_seen == 0, "R3 stop at rise cycle", hi_seen, 0);
        check(fr_seen == 2 * PH, "R2 free keeps running", fr_seen, 2 * PH);
        pci_stop_n = 1'b1;
        repeat (4 * PH) tick();

        // R1/R3: stop one cycle late lets the current phase finish, then low.
        do tick(); while (!pci_rose);
        tick();
        pci_stop_n = 1'b0;
        rises = 0; prev = pci_clk[NP-1];
        repeat (4 * PH) begin tick(); rises += int'(pci_clk[NP-1] && !prev); prev = pci_clk[NP-1]; end
        check(rises == 0 && !pci_clk[NP-1], "R1 late stop finishes phase", rises, 0);
        pci_stop_n = 1'b1;
        repeat (4 * PH) tick();

        // R4/R5: two more processor pulses, then parked.
        do tick(); while (!cpu_rose);
        cpu_stop_n = 1'b0;
        rises = 0; prev = cpu_t;
        repeat (12 * CH) begin tick(); rises += int'(cpu_t && !prev); prev = cpu_t; end
        check(rises == 2, "R4 trailing cpu pulses", rises, 2);
        check(!cpu_t && cpu_c, "R5 parked level", {cpu_t, cpu_c}, 2'b01);
        cpu_stop_n = 1'b1;
        repeat (4 * CH) tick();

        // R6: mode off ignores all three pins.
        stop_mode = 1'b0; pci_stop_n = 1'b0; cpu_stop_n = 1'b0; pwrdn_n = 1'b0;
        hi_seen = 0; fr_seen = 0;
        repeat (8 * PH) begin tick(); hi_seen += pci_clk[NP-1]; fr_seen += cpu_t; end
        check(hi_seen > 0 && fr_seen > 0, "R6 pins ignored", {hi_seen[15:0], fr_seen[15:0]}, 1);
        stop_mode = 1'b1; pci_stop_n = 1'b1; cpu_stop_n = 1'b1; pwrdn_n = 1'b1;
        repeat (4 * PH) tick();

        // R7: disabled outputs low, pair fully off.
        pci_en = '0; cpu_en = 1'b0;
        repeat (2 * PH + 2) tick();
        hi_seen = 0;
        repeat (4 * PH) begin tick(); hi_seen += int'(pci_clk != '0 || cpu_t || cpu_c); end
        check(hi_seen == 0, "R7 disabled outputs low", hi_seen, 0);
        pci_en = '1; cpu_en = 1'b1;
        repeat (4 * PH) tick();

        // R8: power-down drops everything on the next cycle.
        do tick(); while (!pci_rose);
        tick();
        pwrdn_n = 1'b0;
        tick();
        check(pci_clk == '0 && !cpu_t && !cpu_c, "R8 power-down immediate", {pci_clk, cpu_t, cpu_c}, 0);
        hi_seen = 0;
        repeat (4 * PH) begin tick(); hi_seen += int'(pci_clk != '0 || cpu_t || cpu_c); end
        check(hi_seen == 0, "R8 power-down held", hi_seen, 0);
        pwrdn_n = 1'b1;
        repeat (4 * PH) tick();

        // Random mix, checked against the model every cycle.
        for (int n = 0; n < 4000; n++) begin
            tick();
            if ($urandom_range(15, 0) == 0) pci_stop_n = ~pci_stop_n;
            if ($urandom_range(15, 0) == 0) cpu_stop_n = ~cpu_stop_n;
            if ($urandom_range(127, 0) == 0) pwrdn_n = ~pwrdn_n;
            if ($urandom_range(199, 0) == 0) stop_mode = ~stop_mode;
            if ($urandom_range(63, 0) == 0) pci_en = NP'($urandom) | NP'($urandom);
            if ($urandom_range(63, 0) == 0) cpu_en = ($urandom_range(3, 0) != 0);
        end
        finish_run();
    end

endmodule